// File: doc/BRIEF.md
# Staged Line-Control Register Bank

This block is the register bank that sets the framing of a serial port. Software reaches it through a plain single-cycle read/write port with four word addresses. One 23-bit line-control word is spread over three of those addresses:

- the low and mid addresses each hold 8 bits;
- the high address holds the 7 framing bits.

Writes to the low and mid addresses only load staging registers. A write to the high address copies its own bits from the bus, and both staged bytes, into the active word on one clock edge. The UART core therefore never sees a half-updated configuration.

The active word goes out as a parallel bus with a one-cycle update pulse. Its framing fields are also decoded onto separate pins: word length (code and bit count), FIFO enable, two stop bits, parity enable, even parity and break.

The fourth address is the receive-status register. It holds a sticky framing-error flag. The receiver sets the flag by reporting a character whose stop bit was sampled low. Any write to that address clears it.

The bank carries no data stream, so every pin is a plain level or strobe with no valid/ready handshake. A read is combinational from the address and is never back-pressured.

Top module: `lcr_bank`

## Requirements
- R1: A write to the high address (address 2) loads the active word on the same clock edge: bits [22:16] come from write data bits [6:0], bits [15:8] from the mid staging register, and bits [7:0] from the low staging register.
- R2: A write to the low address (0) or mid address (1) leaves the active word and all decoded outputs unchanged.
- R3: Low and mid may be staged in either order before the high write, and both staged values appear in the committed word.
- R4: Staging only the low (or only the mid) byte and then writing high leaves the other byte at the value last staged for it.
- R5: Word-length code (active bits [17:16]) 00, 01, 10 and 11 gives 5, 6, 7 and 8 on the data-bits output.
- R6: The high-register layout is: bit 0-1 word length, bit 2 FIFO enable, bit 3 two stop bits, bit 4 even parity, bit 5 parity enable, bit 6 break; each drives its own output.
- R7: After reset the active word, the staging registers, the update pulse and the framing-error flag are all zero.
- R8: A receive report (rx_valid high) with rx_stop low sets the framing-error flag; a report with rx_stop high does not; the flag stays set until cleared.
- R9: Any write to the status address (3) clears the flag; when a set and a clear fall in the same cycle the flag ends set.
- R10: Reads return committed values, not staged ones, at addresses 0, 1 and 2; address 3 returns the flag in bit 0; all unused bits read zero.
- R11: ctrl_update is high for exactly the one cycle after each high write and low otherwise.
- R12: A high write in the same cycle as a framing-error report commits normally and also sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Word address: 0 low, 1 mid, 2 high, 3 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| rx_valid | input | 1 | Receiver reports a completed character |
| rx_stop | input | 1 | Sampled stop bit of that character |
| ctrl_word | output | 23 | Active line-control word |
| ctrl_update | output | 1 | One-cycle pulse when ctrl_word was just committed |
| wlen_code | output | 2 | Word-length code |
| data_bits | output | 4 | Data bits per frame (5 to 8) |
| fifo_en | output | 1 | FIFO enable |
| two_stop | output | 1 | Two stop bits |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| brk_out | output | 1 | Force break |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
A staging register that leaks into the active word shows on ctrl_word and on the low or mid readback in the cycle right after the low or mid write, before any high write. A wrong commit path shows in the cycle after the high write. That cycle is also where the update pulse must be high, and it must be low in the cycle after. A flag with the wrong priority or the wrong stickiness shows in bit 0 of the status readback one cycle after the receive report or the status write. Sweeping every high-register value and many low/mid pairs in both orders exposes any swapped field or stuck bit within one commit.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam int HI_W     = 7;
  localparam int ADR_LOW  = 0;
  localparam int ADR_MID  = 1;
  localparam int ADR_HIGH = 2;
  localparam int ADR_STAT = 3;
  localparam int MIN_BITS = 5;

  typedef struct packed {
    logic       brk;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
    logic       fifo_en;
    logic [1:0] wlen;
  } hi_fields_t;
endpackage

// File: rtl/lcr_shadow.sv
module lcr_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/lcr_commit.sv
module lcr_commit #(
  parameter int CW   = 23,
  parameter int HI_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [CW-HI_W-1:0] staged,
  input  logic [HI_W-1:0]    hi,
  output logic [CW-1:0]      word,
  output logic               upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      upd  <= 1'b0;
    end else begin
      upd <= commit;
      if (commit) word <= {hi, staged};
    end
  end
endmodule

// File: rtl/lcr_ferr.sv
module lcr_ferr (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/lcr_bank.sv
module lcr_bank
  import lcr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int LO_W   = 8,
  parameter int MI_W   = 8,
  localparam int CW    = LO_W + MI_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic              rx_stop,
  output logic [CW-1:0]     ctrl_word,
  output logic              ctrl_update,
  output logic [1:0]        wlen_code,
  output logic [3:0]        data_bits,
  output logic              fifo_en,
  output logic              two_stop,
  output logic              par_en,
  output logic              par_even,
  output logic              brk_out,
  output logic              frame_err
);
  localparam int NSLOT = 2;
  localparam int SW    = LO_W + MI_W;

  logic sel_lo, sel_mi, sel_hi, sel_st;
  assign sel_lo = bus_addr == ADDR_W'(ADR_LOW);
  assign sel_mi = bus_addr == ADDR_W'(ADR_MID);
  assign sel_hi = bus_addr == ADDR_W'(ADR_HIGH);
  assign sel_st = bus_addr == ADDR_W'(ADR_STAT);

  logic [SW-1:0] staged;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      localparam int SLW = (g == 0) ? LO_W : MI_W;
      localparam int OFS = (g == 0) ? 0 : LO_W;
      logic ld;
      assign ld = bus_wr && ((g == 0) ? sel_lo : sel_mi);
      lcr_shadow #(.W(SLW)) u_shadow (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (ld),
        .d    (bus_wdata[SLW-1:0]),
        .q    (staged[OFS +: SLW])
      );
    end
  endgenerate

  lcr_commit #(.CW(CW), .HI_W(HI_W)) u_commit (
    .clk   (clk),
    .rst_n (rst_n),
    .commit(bus_wr && sel_hi),
    .staged(staged),
    .hi    (bus_wdata[HI_W-1:0]),
    .word  (ctrl_word),
    .upd   (ctrl_update)
  );

  lcr_ferr u_ferr (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (rx_valid && !rx_stop),
    .clr  (bus_wr && sel_st),
    .flag (frame_err)
  );

  hi_fields_t hf;
  assign hf        = hi_fields_t'(ctrl_word[CW-1 -: HI_W]);
  assign wlen_code = hf.wlen;
  assign data_bits = 4'(MIN_BITS) + {2'b00, hf.wlen};
  assign fifo_en   = hf.fifo_en;
  assign two_stop  = hf.two_stop;
  assign par_en    = hf.par_en;
  assign par_even  = hf.par_even;
  assign brk_out   = hf.brk;

  always_comb begin
    bus_rdata = '0;
    if (sel_lo)      bus_rdata[LO_W-1:0] = ctrl_word[LO_W-1:0];
    else if (sel_mi) bus_rdata[MI_W-1:0] = ctrl_word[LO_W +: MI_W];
    else if (sel_hi) bus_rdata[HI_W-1:0] = ctrl_word[CW-1 -: HI_W];
    else if (sel_st) bus_rdata[0]        = frame_err;
  end
endmodule

// File: rtl/lcr_bank_chk.sv
module lcr_bank_chk
  import lcr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int LO_W   = 8,
  parameter int MI_W   = 8,
  localparam int CW    = LO_W + MI_W + HI_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_stop,
  input logic [CW-1:0]     ctrl_word,
  input logic              ctrl_update,
  input logic [1:0]        wlen_code,
  input logic [3:0]        data_bits,
  input logic              fifo_en,
  input logic              two_stop,
  input logic              par_en,
  input logic              par_even,
  input logic              brk_out,
  input logic              frame_err
);
  logic wr_hi, wr_stage, wr_st, bad_stop;
  assign wr_hi    = bus_wr && bus_addr == ADDR_W'(ADR_HIGH);
  assign wr_stage = bus_wr && (bus_addr == ADDR_W'(ADR_LOW) || bus_addr == ADDR_W'(ADR_MID));
  assign wr_st    = bus_wr && bus_addr == ADDR_W'(ADR_STAT);
  assign bad_stop = rx_valid && !rx_stop;

  p_commit_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> ctrl_word[CW-1 -: HI_W] == $past(bus_wdata[HI_W-1:0]));
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stage |=> $stable(ctrl_word));
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(ctrl_word));
  p_bits_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_bits >= 4'd5 && data_bits <= 4'd8);
  p_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_update |-> {brk_out, par_en, par_even, two_stop, fifo_en, wlen_code}
                    == $past(bus_wdata[HI_W-1:0]));
  p_ferr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_stop |=> frame_err);
  p_ferr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !wr_st |=> frame_err);
  p_ferr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st && !bad_stop |=> !frame_err);
  p_rd_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_W'(ADR_LOW) |-> bus_rdata == DATA_W'(ctrl_word[LO_W-1:0]));
  p_rsvd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi && (|bus_wdata[DATA_W-1:HI_W]) |=> ctrl_word[CW-1 -: HI_W] == $past(bus_wdata[HI_W-1:0]));
  p_upd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> ctrl_update);
  p_upd_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_update |-> $past(wr_hi));
endmodule

bind lcr_bank lcr_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_W(LO_W), .MI_W(MI_W)
) u_chk (.*);

// File: tb/tb_lcr_bank.sv
`timescale 1ns/1ps
module tb_lcr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_stop = 1'b1;
  logic [22:0] ctrl_word;
  logic        ctrl_update;
  logic [1:0]  wlen_code;
  logic [3:0]  data_bits;
  logic        fifo_en, two_stop, par_en, par_even, brk_out, frame_err;

  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_lo = 0, m_mi = 0;
  logic [22:0] m_act = 0;

  always #2.5 clk = ~clk;

  lcr_bank dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    case (a)
      2'd0: m_lo = d[7:0];
      2'd1: m_mi = d[7:0];
      2'd2: m_act = {d[6:0], m_mi, m_lo};
      default: ;
    endcase
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    chk(req, bus_rdata, exp);
  endtask

  task automatic check_fields(input string req);
    chk(req, {9'd0, ctrl_word}, {9'd0, m_act});
    chk(req, {30'd0, wlen_code}, {30'd0, m_act[17:16]});
    chk(req, {28'd0, data_bits}, 32'(5 + m_act[17:16]));
    chk(req, {27'd0, brk_out, par_en, par_even, two_stop, fifo_en}, {27'd0, m_act[22:18]});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 word", {9'd0, ctrl_word}, 0);
    chk("R7 update", {31'd0, ctrl_update}, 0);
    chk("R7 flag", {31'd0, frame_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) rd("R7 readback", 2'(a), 0);

    // R2 staged writes do not reach the active word; R10 reads committed
    wr(2'd0, 32'hFFFF_FFA5);
    chk("R2 low stage", {9'd0, ctrl_word}, 0);
    chk("R2 no pulse", {31'd0, ctrl_update}, 0);
    rd("R10 low committed", 2'd0, 0);
    wr(2'd1, 32'h0000_003C);
    chk("R2 mid stage", {9'd0, ctrl_word}, 0);
    rd("R10 mid committed", 2'd1, 0);

    // R1 commit, R11 pulse timing, R10 reserved bits read zero
    wr(2'd2, 32'hFFFF_FF55);
    chk("R1 commit", {9'd0, ctrl_word}, {9'd0, 7'h55, 8'h3C, 8'hA5});
    chk("R11 pulse high", {31'd0, ctrl_update}, 1);
    @(negedge clk);
    chk("R11 pulse low", {31'd0, ctrl_update}, 0);
    rd("R10 high rsvd zero", 2'd2, 32'h55);
    rd("R10 low", 2'd0, 32'hA5);
    rd("R10 mid", 2'd1, 32'h3C);

    // R3 both orders
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a8, b8;
      a8 = 8'(i * 37 + 11);
      b8 = 8'(i * 91 + 3);
      if (i[0]) begin wr(2'd1, {24'd0, b8}); wr(2'd0, {24'd0, a8}); end
      else      begin wr(2'd0, {24'd0, a8}); wr(2'd1, {24'd0, b8}); end
      chk("R3 staged only", {9'd0, ctrl_word}, {9'd0, m_act});
      wr(2'd2, 32'(i));
      chk("R3 commit order", {9'd0, ctrl_word}, {9'd0, 7'(i), b8, a8});
    end

    // R4 partial updates
    wr(2'd0, 32'h0000_0077);
    wr(2'd2, 32'h0000_0001);
    chk("R4 low only", {9'd0, ctrl_word}, {9'd0, 7'h01, m_mi, 8'h77});
    wr(2'd1, 32'h0000_00E1);
    wr(2'd2, 32'h0000_0002);
    chk("R4 mid only", {9'd0, ctrl_word}, {9'd0, 7'h02, 8'hE1, 8'h77});

    // R5 R6 sweep of every high value
    for (int h = 0; h < 128; h++) begin
      wr(2'd2, 32'(h));
      check_fields("R5 R6 sweep");
      rd("R10 high sweep", 2'd2, 32'(h));
    end

    // R8 framing error
    @(negedge clk); rx_valid = 1'b1; rx_stop = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    chk("R8 good stop", {31'd0, frame_err}, 0);
    @(negedge clk); rx_valid = 1'b1; rx_stop = 1'b0;
    @(negedge clk); rx_valid = 1'b0; rx_stop = 1'b1;
    chk("R8 set", {31'd0, frame_err}, 1);
    repeat (3) @(negedge clk);
    chk("R8 sticky", {31'd0, frame_err}, 1);
    rd("R10 status", 2'd3, 1);
    // R9 clear, then set-wins
    wr(2'd3, 32'h0);
    chk("R9 clear", {31'd0, frame_err}, 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3; rx_valid = 1'b1; rx_stop = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; rx_valid = 1'b0; rx_stop = 1'b1;
    chk("R9 set wins", {31'd0, frame_err}, 1);
    wr(2'd3, 32'h0);
    // R12 commit and error in one cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h0000_006B; rx_valid = 1'b1; rx_stop = 1'b0;
    m_act = {7'h6B, m_mi, m_lo};
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; rx_valid = 1'b0; rx_stop = 1'b1;
    chk("R12 commit", {9'd0, ctrl_word}, {9'd0, m_act});
    chk("R12 flag", {31'd0, frame_err}, 1);
    chk("R12 pulse", {31'd0, ctrl_update}, 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule